// File: doc/BRIEF.md
# Frame-Synchronised Serial Sampling Converter Responder

This block is the digital side of a 14-bit sampling converter with a serial output port. It stands in for the real device when a host serial controller is being tested. The block runs on a fast system clock. It watches the serial clock, the frame-sync line and the active-low chip select as ordinary synchronous inputs, and it finds their edges by comparing each input with the value it had one clock earlier. A parallel input stands in for the analog signal. A programmable cycle count sets how long each conversion takes.

A cycle can be started in two ways. A host that drives only the chip select starts a cycle with a falling select. A host that ties the select low starts a cycle with a falling frame sync, after a rising frame sync has first woken the device and put the most significant bit on the data line. After the start, the device counts 24 falling serial-clock edges. These cover the acquisition window and the decode time. At the last of these edges it captures the sample and begins converting. When the programmed time has elapsed, the new word moves into the output register and the device goes to sleep. The word shifted out during any frame is therefore the one converted in the frame before it. If a new start arrives during a conversion, that conversion is abandoned, the old word is kept, and a one-cycle abort flag is raised.

Top module: `frame_adc_responder`

## Requirements
- R1: While reset is held and on the first cycle after it, `dbgState` is 0 (sleep), `sdo` is 0 and `abortFlag` is 0. The stored output word resets to zero.
- R2: A falling `csN` starts a cycle from any phase and at either level of `sclkIn`. The start is visible as `dbgState` = 2 (acquire) one clock after the edge is sampled.
- R3: A rising `fsIn` while asleep moves the device to `dbgState` = 1 (ready). A falling `fsIn` starts a cycle exactly as a falling `csN` does.
- R4: A falling `csN` or a rising `fsIn` puts bit 13 of the stored word on `sdo`. After the k-th rising `sclkIn` edge that follows (k = 1..14), `sdo` carries bit 14-k, so the LSB appears after the 14th rising edge.
- R5: After the 15th rising edge `sdo` is 0, and it stays 0 until the next load. `sdo` is also 0 whenever `csN` is high.
- R6: The 24th falling `sclkIn` edge after a start moves the device to `dbgState` = 3 (convert) and captures `sampleIn` as it is at that edge. Values at earlier edges are not captured.
- R7: A conversion lasts `convCycles` clocks (a setting of 0 acts as 1). The device then returns to `dbgState` = 0 and the captured sample becomes the stored word, which the next frame shifts out.
- R8: A start during a conversion raises `abortFlag` for exactly one clock, moves the device to acquire, and leaves the stored word unchanged.
- R9: A start during acquisition restarts the count, so 24 more falling edges are needed before conversion. No abort is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every other input is sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial clock from the host |
| fsIn | input | 1 | Frame sync from the host |
| csN | input | 1 | Active-low chip select |
| sampleIn | input | 14 | Parallel value standing in for the analog input |
| convCycles | input | 8 | Conversion time in system clocks |
| sdo | output | 1 | Serial data, MSB first |
| dbgState | output | 2 | Phase: 0 sleep, 1 ready, 2 acquire, 3 convert |
| abortFlag | output | 1 | One-clock pulse when a conversion is cut short |

## Verification
A wrong falling-edge count shows on `dbgState` within one clock of the 24th falling edge. The device either enters convert early or is still in acquire after that edge. A fault in the output pipeline stays hidden during the frame that causes it, because the bad word only appears on `sdo` bit by bit in the following frame. Each frame therefore checks all 14 bits against the sample captured one frame earlier. An abort that commits its sample becomes visible only one full frame after the abort.

// File: rtl/fadc_pkg.sv
package fadc_pkg;

  typedef enum logic [1:0] {
    PH_SLEEP = 2'd0,
    PH_READY = 2'd1,
    PH_ACQ   = 2'd2,
    PH_CONV  = 2'd3
  } phase_e;

  // strobes from control to datapath, one clock wide each
  typedef struct packed {
    logic loadWord;     // copy stored word into shifter, drive MSB
    logic shiftStep;    // rising serial clock seen
    logic latchSample;  // last acquisition edge: capture input
    logic commitResult; // conversion finished: hold -> stored word
  } strobe_t;

endpackage

// File: rtl/fadc_ctrl.sv
module fadc_ctrl
  import fadc_pkg::*;
#(
  parameter int SAMPLE_EDGES = 24,
  parameter int CONV_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              fsIn,
  input  logic              csN,
  input  logic [CONV_W-1:0] convCycles,
  output strobe_t           strobe,
  output phase_e            phase,
  output logic              abortFlag
);

  localparam int EC_W = $clog2(SAMPLE_EDGES + 1);
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(SAMPLE_EDGES - 1);

  logic sclkQ, fsQ, csQ;
  logic sclkRise, sclkFall, fsRise, fsFall, csFall, startEv;

  phase_e          nextPhase;
  logic [EC_W-1:0] fallCnt;
  logic [CONV_W-1:0] convCnt;
  logic            convDone;
  logic            enterConv;

  // edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      fsQ   <= 1'b0;
      csQ   <= 1'b1;
    end else begin
      sclkQ <= sclkIn;
      fsQ   <= fsIn;
      csQ   <= csN;
    end
  end

  assign sclkRise = sclkIn & ~sclkQ;
  assign sclkFall = ~sclkIn & sclkQ;
  assign fsRise   = fsIn & ~fsQ;
  assign fsFall   = ~fsIn & fsQ;
  assign csFall   = ~csN & csQ;
  assign startEv  = csFall | fsFall;

  assign convDone  = ({1'b0, convCnt} + (CONV_W+1)'(1)) >= {1'b0, convCycles};
  assign enterConv = (phase == PH_ACQ) && sclkFall && (fallCnt == LAST_EDGE);

  always_comb begin
    nextPhase           = phase;
    strobe.loadWord     = csFall | fsRise;
    strobe.shiftStep    = sclkRise;
    strobe.latchSample  = 1'b0;
    strobe.commitResult = 1'b0;
    if (startEv) begin
      nextPhase = PH_ACQ;
    end else begin
      unique case (phase)
        PH_SLEEP: if (fsRise) nextPhase = PH_READY;
        PH_READY: nextPhase = PH_READY;
        PH_ACQ: begin
          if (enterConv) begin
            nextPhase          = PH_CONV;
            strobe.latchSample = 1'b1;
          end
        end
        PH_CONV: begin
          if (convDone) begin
            nextPhase           = PH_SLEEP;
            strobe.commitResult = 1'b1;
          end
        end
        default: nextPhase = PH_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_SLEEP;
      fallCnt   <= '0;
      convCnt   <= '0;
      abortFlag <= 1'b0;
    end else begin
      phase     <= nextPhase;
      abortFlag <= startEv && (phase == PH_CONV);
      if (startEv)
        fallCnt <= '0;
      else if (phase == PH_ACQ && sclkFall && !enterConv)
        fallCnt <= fallCnt + EC_W'(1);
      else if (enterConv)
        fallCnt <= '0;
      if (phase == PH_CONV && !startEv && !convDone)
        convCnt <= convCnt + CONV_W'(1);
      else
        convCnt <= '0;
    end
  end

endmodule

// File: rtl/fadc_data.sv
module fadc_data
  import fadc_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] sampleIn,
  output logic              sdoBit
);

  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(DATA_W + 1);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] resultReg;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  // sample capture and result pipeline
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      resultReg <= '0;
    end else begin
      if (strobe.latchSample)  holdReg   <= sampleIn;
      if (strobe.commitResult) resultReg <= holdReg;
    end
  end

  // output shifter: first rising edge keeps MSB, later ones advance
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= IDLE_CNT;
      sdoBit   <= 1'b0;
    end else if (strobe.loadWord) begin
      shiftReg <= resultReg;
      bitCnt   <= '0;
      sdoBit   <= resultReg[DATA_W-1];
    end else if (strobe.shiftStep) begin
      if (bitCnt == '0) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end else if (bitCnt < LAST_BIT) begin
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
        sdoBit   <= shiftReg[DATA_W-2];
        bitCnt   <= bitCnt + CNT_W'(1);
      end else if (bitCnt == LAST_BIT) begin
        sdoBit <= 1'b0;
        bitCnt <= IDLE_CNT;
      end
    end
  end

endmodule

// File: rtl/frame_adc_responder.sv
module frame_adc_responder
  import fadc_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int SAMPLE_EDGES = 24,
  parameter int CONV_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              fsIn,
  input  logic              csN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [CONV_W-1:0] convCycles,
  output logic              sdo,
  output logic [1:0]        dbgState,
  output logic              abortFlag
);

  strobe_t strobe;
  phase_e  phase;
  logic    sdoBit;

  fadc_ctrl #(.SAMPLE_EDGES(SAMPLE_EDGES), .CONV_W(CONV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .fsIn(fsIn), .csN(csN),
    .convCycles(convCycles), .strobe(strobe), .phase(phase),
    .abortFlag(abortFlag)
  );

  fadc_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleIn(sampleIn),
    .sdoBit(sdoBit)
  );

  assign sdo      = sdoBit & ~csN;
  assign dbgState = phase;

endmodule

// File: rtl/fadc_checker.sv
module fadc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sclkIn,
  input logic       fsIn,
  input logic       csN,
  input logic       sdo,
  input logic [1:0] dbgState,
  input logic       abortFlag
);

  // R8: an abort only ever comes out of the convert phase
  assert_abort_from_conv_R8: assert property (@(posedge clk) disable iff (!rstN)
    abortFlag |-> $past(dbgState) == 2'd3);

  // R8: the abort flag is a single-clock pulse
  assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    abortFlag |=> !abortFlag);

  // R6: convert is only entered from acquire
  assert_conv_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dbgState == 2'd3 && $past(dbgState) != 2'd3) |-> $past(dbgState) == 2'd2);

  // R7: sleep is only re-entered from convert
  assert_sleep_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dbgState == 2'd0 && $past(dbgState) != 2'd0) |-> $past(dbgState) == 2'd3);

  // R3: ready is only entered from sleep
  assert_ready_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dbgState == 2'd1 && $past(dbgState) != 2'd1) |-> $past(dbgState) == 2'd0);

  // R4: without any input edge the data line holds its bit
  assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $stable(csN) && $stable(sclkIn) && $stable(fsIn)) |=> (csN || $stable(sdo)));

endmodule

bind frame_adc_responder fadc_checker u_chk (
  .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .fsIn(fsIn), .csN(csN),
  .sdo(sdo), .dbgState(dbgState), .abortFlag(abortFlag)
);

// File: tb/frame_adc_responder_test.sv
module frame_adc_responder_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkIn = 1'b0;
  logic        fsIn = 1'b0;
  logic        csN = 1'b1;
  logic [13:0] sampleIn = '0;
  logic [7:0]  convCycles = 8'd1;
  logic        sdo;
  logic [1:0]  dbgState;
  logic        abortFlag;

  int testsRun = 0;
  int testsFailed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_adc_responder uut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .fsIn(fsIn), .csN(csN),
    .sampleIn(sampleIn), .convCycles(convCycles), .sdo(sdo),
    .dbgState(dbgState), .abortFlag(abortFlag)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drives serial clock pulses from a started frame; preFalls falls already seen
  task automatic runFrame(input logic [13:0] expWord, input logic [13:0] newSample,
                          input int convN, input int preFalls, input bit waitConv);
    convCycles = 8'(convN);
    sampleIn   = ~newSample;
    for (int k = 1; k <= 24 - preFalls; k++) begin
      sclkIn = 1'b1;
      tick();
      if (k <= 14) check("R4 sdo bit after rise", int'(sdo), int'(expWord[14-k]));
      else         check("R5 sdo idle after LSB", int'(sdo), 0);
      if (k + preFalls == 24) sampleIn = newSample;
      sclkIn = 1'b0;
      tick();
      if (k + preFalls == 24) begin
        sampleIn = ~newSample;
        check("R6 convert after 24th fall", int'(dbgState), 3);
      end else if (k == 23 - preFalls) begin
        check("R6 still acquiring at 23rd fall", int'(dbgState), 2);
      end
    end
    if (waitConv) begin
      for (int i = 1; i < convN; i++) tick();
      check("R7 convert lasts convCycles", int'(dbgState), 3);
      if (convN > 1 || convN == 1) begin
        tick();
        check("R7 sleep after conversion", int'(dbgState), 0);
      end
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) tick();
    check("R1 reset state", int'(dbgState), 0);
    rstN = 1'b1;
    tick();
    check("R1 state after reset", int'(dbgState), 0);
    check("R1 sdo after reset", int'(sdo), 0);
    check("R1 abort after reset", int'(abortFlag), 0);
  endtask

  task automatic testCsStart();
    csN = 1'b0;
    tick();
    check("R2 cs fall starts", int'(dbgState), 2);
    check("R4 MSB of reset word", int'(sdo), 0);
    runFrame(14'h0000, 14'h2A5C, 5, 0, 1);
  endtask

  task automatic testCsStartSclkHigh();
    csN = 1'b1;
    tick();
    check("R5 sdo masked by cs", int'(sdo), 0);
    sclkIn = 1'b1;
    tick();
    csN = 1'b0;
    tick();
    check("R2 start with sclk high", int'(dbgState), 2);
    check("R4 MSB on cs fall", int'(sdo), 1);
    sclkIn = 1'b0;
    tick();
    check("R2 acquiring after first fall", int'(dbgState), 2);
    runFrame(14'h2A5C, 14'h2337, 3, 1, 1);
  endtask

  task automatic testFsFrame();
    fsIn = 1'b1;
    tick();
    check("R3 fs rise wakes to ready", int'(dbgState), 1);
    check("R3 MSB on fs rise", int'(sdo), 1);
    fsIn = 1'b0;
    tick();
    check("R3 fs fall starts", int'(dbgState), 2);
    runFrame(14'h2337, 14'h0001, 1, 0, 1);
  endtask

  task automatic testAbort();
    fsIn = 1'b1; tick();
    fsIn = 1'b0; tick();
    runFrame(14'h0001, 14'h3C3C, 20, 0, 0);
    fsIn = 1'b1;
    tick();
    check("R8 fs rise does not end convert", int'(dbgState), 3);
    fsIn = 1'b0;
    tick();
    check("R8 abort flag raised", int'(abortFlag), 1);
    check("R8 restart in acquire", int'(dbgState), 2);
    tick();
    check("R8 abort flag single clock", int'(abortFlag), 0);
    runFrame(14'h0001, 14'h2001, 3, 0, 1);
  endtask

  task automatic testRetrigger();
    fsIn = 1'b1; tick();
    fsIn = 1'b0; tick();
    for (int k = 0; k < 10; k++) begin
      sclkIn = 1'b1; tick();
      sclkIn = 1'b0; tick();
    end
    fsIn = 1'b1; tick();
    fsIn = 1'b0; tick();
    check("R9 restart stays in acquire", int'(dbgState), 2);
    check("R9 no abort on restart", int'(abortFlag), 0);
    runFrame(14'h2001, 14'h15AA, 2, 0, 1);
  endtask

  task automatic testMaskedWake();
    csN = 1'b1;
    tick();
    check("R5 sdo low with cs high", int'(sdo), 0);
    fsIn = 1'b1;
    tick();
    check("R3 wake with cs high", int'(dbgState), 1);
    check("R5 masked MSB", int'(sdo), 0);
    csN = 1'b0;
    tick();
    check("R2 cs fall from ready", int'(dbgState), 2);
    check("R4 MSB of latched word", int'(sdo), 0);
    fsIn = 1'b0;
    tick();
    check("R9 fs fall restarts", int'(dbgState), 2);
    runFrame(14'h15AA, 14'h0FF0, 4, 0, 1);
  endtask

  initial begin
    testReset();
    testCsStart();
    testCsStartSclkHigh();
    testFsFrame();
    testAbort();
    testRetrigger();
    testMaskedWake();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule